// File: doc/BRIEF.md
# DRAM Address/Control Net Multiplexer

This block sits between a memory controller that has only ten multiplexed address lines and a set of memory-module nets shared across the board. Modules made from 1 Mbit or 4 Mbit parts are addressed 10x10. Modules made from 16 Mbit parts need 11x11 or 12x10 addressing. The block supplies the two extra address bits by borrowing two control nets: the column parity-strobe net and the bank-select-3 net. When the controller marks a request as going to a 16 Mbit module, those nets carry the upper address bits. For every other request they carry their normal control signals.

A 40-bit ECC module uses the bank-select net as a data line. When such a module is addressed, the block releases that net so that the two drivers do not fight. Which nets may be released is set by a parameter mask.

The mode and tri-state choices are held in registers. These registers update only in a safe window: the row strobe must be inactive, and a parameterised number of clocks must have passed since the strobe last changed level. The address and control values themselves pass through combinationally, with no added latency.

Top module: `dram_net_mux`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, every net carries its legacy control input and every net driver is enabled (net_oe_o all ones). The wide request and tri-state request inputs are ignored during this time.
- R2: In legacy mode, net_o[0] equals legacy_ctl_i[0] (parity strobe) and net_o[1] equals legacy_ctl_i[1] (bank select 3).
- R3: In wide mode, net_o[0] equals ma_hi_i[0] (address bit 10) and net_o[1] equals ma_hi_i[1] (address bit 11).
- R4: At a rising clock edge the mode register loads the decode, with wide_req_n_i = 0 selecting wide mode and 1 selecting legacy mode. The load happens only if all of the following hold: ras_n_i is 1, ras_n_i is unchanged since the previous edge, and at least GUARD_CYC edges have passed since the last change of ras_n_i (or since reset). With the defaults, the first load after reset happens at edge GUARD_CYC+1.
- R5: Changes of wide_req_n_i or hiz_req_i have no effect on the nets while ras_n_i is 0. They also have no effect during the guard period after any edge of ras_n_i.
- R6: The tri-state request is captured under the same gating as the mode. While it is captured, each net whose bit is set in HIZ_NETS (default: net 1 only) has net_oe_o low and net_o driven 0. All other nets stay enabled.
- R7: A released net stays released in either mode, so the tri-state request overrides the multiplexer choice. Net 0 still follows the selected source.
- R8: net_o follows changes of ma_hi_i and legacy_ctl_i within the same cycle, with no register stage in that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n_i | input | 1 | Row address strobe, active low, synchronous to clk |
| wide_req_n_i | input | 1 | Active-low decode: request targets a 16 Mbit module |
| hiz_req_i | input | 1 | Request targets a 40-bit ECC module that owns a shared net |
| ma_hi_i | input | NETS | Upper address bits from the controller (bit 0 = bit 10, bit 1 = bit 11) |
| legacy_ctl_i | input | NETS | Legacy control signals (bit 0 = parity strobe, bit 1 = bank select 3) |
| net_o | output | NETS | Value driven onto each shared net |
| net_oe_o | output | NETS | Driver enable for each shared net, 1 = drive |

## Verification
The assertions take for granted that ras_n_i is synchronous to clk and is held stable from edge to edge. They also assume the controller inputs change only between edges. The properties that tie the nets to their sources assume that the inputs settle before they are sampled. The stimulus meets these assumptions by driving every input on the falling clock edge. The strobe toggles at random intervals, some longer and some shorter than the guard period. The request inputs change freely, including while the strobe is active, so the blocked windows are exercised as well as the open ones.

// File: rtl/dnm_pkg.sv
package dnm_pkg;
   typedef enum logic {
      SEL_LEGACY = 1'b0,
      SEL_WIDE   = 1'b1
   } net_sel_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/dnm_guard.sv
module dnm_guard #(
   parameter int unsigned GUARD_CYC = 4,
   parameter int unsigned CNT_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n_i,
   output logic             open_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GUARD_CYC);

   logic             ras_q;
   logic [CNT_W-1:0] cnt_q;
   logic             edge_w;
   logic             done_w;

   assign edge_w = ras_n_i ^ ras_q;
   assign done_w = (cnt_q == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q <= 1'b1;
         cnt_q <= '0;
      end else begin
         ras_q <= ras_n_i;
         if (edge_w) begin
            cnt_q <= '0;
         end else if (!done_w) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign open_o = ras_n_i & ~edge_w & done_w;
   assign cnt_o  = cnt_q;
endmodule

// File: rtl/dnm_sel_reg.sv
module dnm_sel_reg
   import dnm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load_i,
   input  logic     wide_req_n_i,
   input  logic     hiz_req_i,
   output net_sel_e sel_o,
   output logic     hiz_o
);
   net_sel_e sel_q;
   logic     hiz_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= SEL_LEGACY;
         hiz_q <= 1'b0;
      end else if (load_i) begin
         sel_q <= wide_req_n_i ? SEL_LEGACY : SEL_WIDE;
         hiz_q <= hiz_req_i;
      end
   end

   assign sel_o = sel_q;
   assign hiz_o = hiz_q;
endmodule

// File: rtl/dnm_net_drv.sv
module dnm_net_drv
   import dnm_pkg::*;
#(
   parameter bit HIZ_ABLE = 1'b0
) (
   input  net_sel_e sel_i,
   input  logic     hiz_i,
   input  logic     addr_i,
   input  logic     ctl_i,
   output logic     net_o,
   output logic     oe_o
);
   logic pick_w;

   always_comb begin
      pick_w = (sel_i == SEL_WIDE) ? addr_i : ctl_i;
      oe_o   = ~(HIZ_ABLE & hiz_i);
      net_o  = oe_o & pick_w;
   end
endmodule

// File: rtl/dram_net_mux.sv
module dram_net_mux
   import dnm_pkg::*;
#(
   parameter int unsigned    NETS      = 2,
   parameter int unsigned    GUARD_CYC = 4,
   parameter logic [NETS-1:0] HIZ_NETS = 2'b10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ras_n_i,
   input  logic            wide_req_n_i,
   input  logic            hiz_req_i,
   input  logic [NETS-1:0] ma_hi_i,
   input  logic [NETS-1:0] legacy_ctl_i,
   output logic [NETS-1:0] net_o,
   output logic [NETS-1:0] net_oe_o
);
   localparam int unsigned CNT_W = cnt_width(GUARD_CYC);

   if (NETS < 1 || NETS > 8) begin : g_bad_nets
      $error("dram_net_mux: NETS must be 1..8");
   end
   if (GUARD_CYC < 1) begin : g_bad_guard
      $error("dram_net_mux: GUARD_CYC must be at least 1");
   end

   logic             load_w;
   logic [CNT_W-1:0] guard_cnt;
   net_sel_e         sel_w;
   logic             hiz_w;

   dnm_guard #(
      .GUARD_CYC (GUARD_CYC),
      .CNT_W     (CNT_W)
   ) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .ras_n_i (ras_n_i),
      .open_o  (load_w),
      .cnt_o   (guard_cnt)
   );

   dnm_sel_reg u_sel (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load_w),
      .wide_req_n_i (wide_req_n_i),
      .hiz_req_i    (hiz_req_i),
      .sel_o        (sel_w),
      .hiz_o        (hiz_w)
   );

   for (genvar n = 0; n < NETS; n++) begin : g_net
      dnm_net_drv #(
         .HIZ_ABLE (HIZ_NETS[n])
      ) u_drv (
         .sel_i  (sel_w),
         .hiz_i  (hiz_w),
         .addr_i (ma_hi_i[n]),
         .ctl_i  (legacy_ctl_i[n]),
         .net_o  (net_o[n]),
         .oe_o   (net_oe_o[n])
      );
   end
endmodule

// File: rtl/dnm_checker.sv
module dnm_checker
   import dnm_pkg::*;
#(
   parameter int unsigned     NETS      = 2,
   parameter int unsigned     GUARD_CYC = 4,
   parameter int unsigned     CNT_W     = 3,
   parameter logic [NETS-1:0] HIZ_NETS  = 2'b10
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ras_n_i,
   input logic [NETS-1:0] ma_hi_i,
   input logic [NETS-1:0] legacy_ctl_i,
   input logic [NETS-1:0] net_o,
   input logic [NETS-1:0] net_oe_o,
   input net_sel_e        sel,
   input logic            hiz,
   input logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GUARD_CYC);

   AST_SEL_HELD_RAS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n_i |=> $stable(sel)); // R5
   AST_HIZ_HELD_RAS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n_i |=> $stable(hiz)); // R6
   AST_SEL_HELD_IN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != LIMIT) |=> $stable(sel)); // R4
   AST_HIZ_HELD_IN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != LIMIT) |=> $stable(hiz)); // R6

   for (genvar n = 0; n < NETS; n++) begin : g_chk
      AST_WIDE_ROUTE: assert property (@(negedge clk) disable iff (!rst_n)
         (sel == SEL_WIDE && net_oe_o[n]) |-> (net_o[n] == ma_hi_i[n])); // R3
      AST_LEGACY_ROUTE: assert property (@(negedge clk) disable iff (!rst_n)
         (sel == SEL_LEGACY && net_oe_o[n]) |-> (net_o[n] == legacy_ctl_i[n])); // R2
      AST_QUIET_WHEN_OFF: assert property (@(negedge clk) disable iff (!rst_n)
         !net_oe_o[n] |-> !net_o[n]); // R6
      if (HIZ_NETS[n]) begin : g_hz
         AST_HIZ_RELEASES: assert property (@(negedge clk) disable iff (!rst_n)
            hiz |-> !net_oe_o[n]); // R7
      end else begin : g_nohz
         AST_ALWAYS_DRIVEN: assert property (@(negedge clk) disable iff (!rst_n)
            hiz |-> net_oe_o[n]); // R6
      end
   end
endmodule

bind dram_net_mux dnm_checker #(
   .NETS      (NETS),
   .GUARD_CYC (GUARD_CYC),
   .CNT_W     (CNT_W),
   .HIZ_NETS  (HIZ_NETS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ras_n_i      (ras_n_i),
   .ma_hi_i      (ma_hi_i),
   .legacy_ctl_i (legacy_ctl_i),
   .net_o        (net_o),
   .net_oe_o     (net_oe_o),
   .sel          (sel_w),
   .hiz          (hiz_w),
   .cnt          (guard_cnt)
);

// File: tb/sim_dram_net_mux.sv
module sim_dram_net_mux;
   localparam int G = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ras_n = 1'b1;
   logic       wide_n = 1'b1;
   logic       hiz = 1'b0;
   logic [1:0] ma = 2'b00;
   logic [1:0] ctl = 2'b00;
   logic [1:0] net;
   logic [1:0] oe;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   logic m_sel, m_hiz, m_ras_q;
   int   m_cnt;

   always #2 clk = ~clk;

   dram_net_mux #(.NETS(2), .GUARD_CYC(G), .HIZ_NETS(2'b10)) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .ras_n_i      (ras_n),
      .wide_req_n_i (wide_n),
      .hiz_req_i    (hiz),
      .ma_hi_i      (ma),
      .legacy_ctl_i (ctl),
      .net_o        (net),
      .net_oe_o     (oe)
   );

   // Reference state derived from R1, R4, R5, R6
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sel <= 1'b0; m_hiz <= 1'b0; m_ras_q <= 1'b1; m_cnt <= 0;
      end else begin
         if (ras_n && (ras_n == m_ras_q) && (m_cnt == G)) begin
            m_sel <= !wide_n;
            m_hiz <= hiz;
         end
         if (ras_n != m_ras_q) m_cnt <= 0;
         else if (m_cnt < G)   m_cnt <= m_cnt + 1;
         m_ras_q <= ras_n;
      end
   end

   function automatic logic [1:0] exp_net(input logic s, input logic h,
                                          input logic [1:0] a, input logic [1:0] c);
      logic [1:0] r;
      r = s ? a : c;
      if (h) r[1] = 1'b0;
      return r;
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [1:0] act, input logic [1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   task automatic chk_model();
      string tag;
      tag = m_hiz ? "R7" : (m_sel ? "R3" : "R2");
      chk(tag, "net", net, exp_net(m_sel, m_hiz, ma, ctl));
      chk("R6", "oe", oe, m_hiz ? 2'b01 : 2'b11);
   endtask

   initial begin
      void'($urandom(32'h5EED_0A11));
      ctl = 2'b01; ma = 2'b10; wide_n = 1'b0; hiz = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "net in reset", net, 2'b01);
      chk("R1", "oe in reset", oe, 2'b11);
      hiz = 1'b0;
      rst_n = 1'b1;
      // R4: first load after G+1 edges since reset
      for (int i = 1; i <= G; i++) begin
         @(negedge clk);
         chk("R4", "guard after reset", net, 2'b01);
      end
      @(negedge clk);
      chk("R4", "first load wide", net, 2'b10);
      // R5: strobe active blocks request
      ras_n = 1'b0; wide_n = 1'b1;
      repeat (20) begin
         @(negedge clk);
         chk("R5", "held while ras active", net, 2'b10);
      end
      ras_n = 1'b1;
      for (int i = 0; i <= G; i++) begin
         @(negedge clk);
         chk("R5", "held in guard", net, 2'b10);
      end
      @(negedge clk);
      chk("R4", "load legacy after guard", net, 2'b01);
      // R7: tri-state overrides wide mode
      wide_n = 1'b0; hiz = 1'b1; ma = 2'b11;
      @(negedge clk);
      chk("R7", "hiz in wide net", net, 2'b01);
      chk("R7", "hiz in wide oe", oe, 2'b01);
      // R8: same-cycle address flow
      ma = 2'b10; #1;
      chk("R8", "address follows", net, 2'b00);
      ma = 2'b01; #1;
      chk("R8", "address follows", net, 2'b01);
      hiz = 1'b0;
      @(negedge clk);
      ctl = 2'b10; ma = 2'b01; wide_n = 1'b1;
      @(negedge clk);
      ctl = 2'b01; #1;
      chk("R8", "control follows", net, 2'b01);
      // Random phase
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         chk_model();
         if ($urandom % 6 == 0) ras_n = ~ras_n;
         if ($urandom % 4 == 0) wide_n = 1'($urandom);
         if ($urandom % 8 == 0) hiz = 1'($urandom);
         ma  = 2'($urandom);
         ctl = 2'($urandom);
         #1;
         chk_model();
      end
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule